// File: doc/BRIEF.md
# Configurable Serial Shift Port

This block is the synchronous serial shift port of a small 4-bit controller. It moves one 8-bit word at a time over a data-out pin and takes a word in from a data-in pin. The data-in pin can also act as one shared data line. The clock pin either drives the serial clock or receives it. Software picks the clock source at run time. With the internal source, the shift clock is the selected prescaler tap divided by two. With the external source, the clock pin is an input. Its level passes through a two-flop synchronizer into the system clock domain and is then edge-detected there. The bit order is a static build option: most significant bit first or least significant bit first.

Outgoing data changes on the falling shift-clock edge. Incoming data is captured on the rising edge. After eight rising edges a done flag is raised, and it holds until the next transfer starts. When the serial function is switched off, the clock pin becomes a general clock output and carries the prescaler tap directly.

Top module: `ser_shift_port`

## Requirements
- R1: After reset, done=0, busy=0, sdo=1, sdio_oe=0, and with the internal source selected sck_out=1.
- R2: With LSB_FIRST=0, the bits appear on sdo in the order tx_data[7] down to tx_data[0]. The first bit received lands in rx_data[7] and the last in rx_data[0].
- R3: With LSB_FIRST=1, the bits appear on sdo in the order tx_data[0] up to tx_data[7]. The first bit received lands in rx_data[0] and the last in rx_data[7].
- R4: sdo changes only on falling shift-clock edges, so it is stable while the clock is high. sdi_in is captured on rising edges.
- R5: done rises on the eighth rising edge, in the same cycle that busy falls. done stays set until an accepted start clears it, and that start also sets busy.
- R6: With the internal source, sck_out idles high while no transfer runs. During a transfer it toggles once per rising edge of pre_tap, so one shift-clock period equals two tap periods. sck_oe is 1.
- R7: With use_ext_clk=1, sck_oe=0 and the transfer is clocked by the synchronized level of sck_in. High-to-low transitions act as falling edges and low-to-high transitions as rising edges.
- R8: With ser_en=0, sck_out follows pre_tap, sck_oe=1, and start is ignored (busy stays 0).
- R9: sdio_oe=1 exactly when ser_en, shared_io and shared_dir_out are all 1. sdio_out always carries the sdo bit.
- R10: A start pulse during a transfer is ignored. The word in flight is not reloaded, and done still arrives after eight rising edges in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en | input | 1 | Serial function enable; 0 turns the clock pin into a clock output |
| use_ext_clk | input | 1 | 1 selects the external shift clock on sck_in |
| shared_io | input | 1 | Data-in pin used as a shared data line |
| shared_dir_out | input | 1 | Shared line drives outward when 1 |
| start | input | 1 | Begin a transfer (accepted when idle and enabled) |
| tx_data | input | DATA_W | Word loaded at start |
| pre_tap | input | 1 | Selected prescaler tap level |
| sck_in | input | 1 | Clock pin input level |
| sdi_in | input | 1 | Data-in pin level |
| sck_out | output | 1 | Clock pin output level |
| sck_oe | output | 1 | Clock pin output enable |
| sdo | output | 1 | Serial data-out pin |
| sdio_out | output | 1 | Shared data line output value |
| sdio_oe | output | 1 | Shared data line output enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer-complete flag |
| rx_data | output | DATA_W | Received word |

## Verification
The main function is exercised with words whose bit patterns are asymmetric: a single set bit at one end, all ones against all zeros, and alternating or irregular mixes. Two instances that differ only in bit order are driven side by side from one serial stream. A bit reversal, a shift in the wrong direction, or an off-by-one bit position therefore shows up on at least one of them. The same patterns are run from the internal and the external clock source. This separates errors in the synchronizer and edge logic from errors in the shifter itself. A restart pulse in the middle of a transfer checks that the word in flight is not reloaded.

// File: rtl/ser_shift_pkg.sv
package ser_shift_pkg;

    // One-cycle shift-clock edge events in the system clock domain
    typedef struct packed {
        logic rise;
        logic fall;
    } shift_evt_t;

endpackage

// File: rtl/ser_clk_gen.sv
module ser_clk_gen #(
    parameter int SYNC_N = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pre_tap,
    input  logic                      use_ext,
    input  logic                      run,
    input  logic                      sck_in,
    output logic                      sck_int,
    output ser_shift_pkg::shift_evt_t evt
);
    // sync[SYNC_N-1] is the synchronized level, sync[SYNC_N] its previous value
    typedef struct packed {
        logic              tap_prev;
        logic              sck;
        logic [SYNC_N:0]   sync;
    } clk_st_t;

    clk_st_t st_d, st_q;
    logic    tap_rise;
    logic    int_toggle;
    logic    ext_rise;
    logic    ext_fall;

    always_comb begin
        st_d          = st_q;
        st_d.tap_prev = pre_tap;
        st_d.sync     = {st_q.sync[SYNC_N-1:0], sck_in};
        tap_rise      = pre_tap & ~st_q.tap_prev;
        int_toggle    = run & ~use_ext & tap_rise;
        if (int_toggle) begin
            st_d.sck = ~st_q.sck;
        end
        ext_rise = st_q.sync[SYNC_N-1] & ~st_q.sync[SYNC_N];
        ext_fall = ~st_q.sync[SYNC_N-1] & st_q.sync[SYNC_N];
        if (use_ext) begin
            evt.rise = run & ext_rise;
            evt.fall = run & ext_fall;
        end else begin
            evt.rise = int_toggle & ~st_q.sck;
            evt.fall = int_toggle & st_q.sck;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tap_prev <= 1'b0;
            st_q.sck      <= 1'b1;
            st_q.sync     <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sck_int = st_q.sck;

endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
    parameter int DATA_W    = 8,
    parameter bit LSB_FIRST = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_ok,
    input  logic [DATA_W-1:0]         tx_data,
    input  ser_shift_pkg::shift_evt_t evt,
    input  logic                      din,
    output logic                      out_bit,
    output logic                      busy,
    output logic                      done,
    output logic [DATA_W-1:0]         word
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
        logic              done;
        logic              obit;
    } shf_st_t;

    shf_st_t           st_d, st_q;
    logic              next_bit;
    logic [DATA_W-1:0] shifted;

    // Same register shifts data out at one end and in at the other
    generate
        if (LSB_FIRST) begin : g_lsb_first
            assign next_bit = st_q.sh[0];
            assign shifted  = {din, st_q.sh[DATA_W-1:1]};
        end else begin : g_msb_first
            assign next_bit = st_q.sh[DATA_W-1];
            assign shifted  = {st_q.sh[DATA_W-2:0], din};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start_ok) begin
                st_d.sh   = tx_data;
                st_d.cnt  = '0;
                st_d.busy = 1'b1;
                st_d.done = 1'b0;
            end
        end else begin
            if (evt.fall) begin
                st_d.obit = next_bit;
            end
            if (evt.rise) begin
                st_d.sh  = shifted;
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == LAST_CNT) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh   <= '0;
            st_q.cnt  <= '0;
            st_q.busy <= 1'b0;
            st_q.done <= 1'b0;
            st_q.obit <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_bit = st_q.obit;
    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign word    = st_q.sh;

endmodule

// File: rtl/ser_shift_port.sv
module ser_shift_port #(
    parameter int DATA_W    = 8,
    parameter int SYNC_N    = 2,
    parameter bit LSB_FIRST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en,
    input  logic              use_ext_clk,
    input  logic              shared_io,
    input  logic              shared_dir_out,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              pre_tap,
    input  logic              sck_in,
    input  logic              sdi_in,
    output logic              sck_out,
    output logic              sck_oe,
    output logic              sdo,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_data
);
    ser_shift_pkg::shift_evt_t evt;
    logic                      sck_int;
    logic                      start_ok;

    assign start_ok = start & ser_en;

    ser_clk_gen #(
        .SYNC_N (SYNC_N)
    ) u_clk_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .pre_tap (pre_tap),
        .use_ext (use_ext_clk),
        .run     (busy),
        .sck_in  (sck_in),
        .sck_int (sck_int),
        .evt     (evt)
    );

    ser_shifter #(
        .DATA_W    (DATA_W),
        .LSB_FIRST (LSB_FIRST)
    ) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_ok (start_ok),
        .tx_data  (tx_data),
        .evt      (evt),
        .din      (sdi_in),
        .out_bit  (sdo),
        .busy     (busy),
        .done     (done),
        .word     (rx_data)
    );

    // Clock pin: serial clock when enabled, plain tap output otherwise
    assign sck_out  = ser_en ? sck_int : pre_tap;
    assign sck_oe   = ~(ser_en & use_ext_clk);
    assign sdio_out = sdo;
    assign sdio_oe  = ser_en & shared_io & shared_dir_out;

endmodule

// File: rtl/ser_shift_port_chk.sv
module ser_shift_port_chk (
    input logic clk,
    input logic rst_n,
    input logic ser_en,
    input logic use_ext_clk,
    input logic sdo,
    input logic sck_out,
    input logic busy,
    input logic done
);
    // R4
    sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en && !use_ext_clk && $changed(sdo)) |-> !sck_out);

    // R5
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R6
    idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en && !use_ext_clk && !busy) |-> sck_out);

    // R8
    no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_en && !busy) |=> !busy);

endmodule

bind ser_shift_port ser_shift_port_chk u_chk (.*);

// File: tb/ser_shift_port_bench.sv
module ser_shift_port_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic       ser_en = 1'b1, use_ext_clk = 1'b0, shared_io = 1'b0, shared_dir_out = 1'b0;
    logic       start = 1'b0, sck_in = 1'b1, sdi_in = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [3:0] tap_cnt;
    logic       pre_tap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap_cnt <= '0;
        else        tap_cnt <= tap_cnt + 1'b1;
    end
    assign pre_tap = tap_cnt[0];

    logic       sck_out_m, sck_oe_m, sdo_m, sdio_out_m, sdio_oe_m, busy_m, done_m;
    logic [7:0] rx_m;
    logic       sck_out_l, sck_oe_l, sdo_l, sdio_out_l, sdio_oe_l, busy_l, done_l;
    logic [7:0] rx_l;

    ser_shift_port u_ser_shift_port (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .use_ext_clk(use_ext_clk),
        .shared_io(shared_io), .shared_dir_out(shared_dir_out), .start(start),
        .tx_data(tx_data), .pre_tap(pre_tap), .sck_in(sck_in), .sdi_in(sdi_in),
        .sck_out(sck_out_m), .sck_oe(sck_oe_m), .sdo(sdo_m), .sdio_out(sdio_out_m),
        .sdio_oe(sdio_oe_m), .busy(busy_m), .done(done_m), .rx_data(rx_m));

    ser_shift_port #(.LSB_FIRST(1'b1)) u_ser_shift_port_lsb (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .use_ext_clk(use_ext_clk),
        .shared_io(shared_io), .shared_dir_out(shared_dir_out), .start(start),
        .tx_data(tx_data), .pre_tap(pre_tap), .sck_in(sck_in), .sdi_in(sdi_in),
        .sck_out(sck_out_l), .sck_oe(sck_oe_l), .sdo(sdo_l), .sdio_out(sdio_out_l),
        .sdio_oe(sdio_oe_l), .busy(busy_l), .done(done_l), .rx_data(rx_l));

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Vector fields: [16] external clock, [15:8] word to send, [7:0] serial stream (bit k sent k-th)
    localparam logic [16:0] VEC [6] = '{
        {1'b0, 8'hA5, 8'h3C},
        {1'b0, 8'h01, 8'h80},
        {1'b0, 8'hFF, 8'h00},
        {1'b1, 8'h96, 8'hC3},
        {1'b1, 8'h00, 8'hFF},
        {1'b0, 8'h5A, 8'h71}
    };

    task automatic run_xfer(input logic ext, input logic [7:0] tx, input logic [7:0] stream,
                            input int restart_at);
        logic [7:0] om, ol, em;
        logic       r4_ok;
        om = '0; ol = '0; em = '0; r4_ok = 1'b1;
        use_ext_clk = ext;
        sck_in = 1'b1;
        tx_data = tx;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (ext) begin
                sck_in = 1'b0;
                repeat (4) @(negedge clk);
                if (k == 0) chk(sck_oe_m == 1'b0, "R7 clock pin is input", {7'd0, sck_oe_m}, 8'd0);
            end else begin
                while (sck_out_m !== 1'b0) @(negedge clk);
            end
            om[7-k] = sdo_m;
            ol[k]   = sdo_l;
            em[7-k] = stream[k];
            sdi_in  = stream[k];
            if (k == restart_at) begin
                tx_data = ~tx;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            if (ext) begin
                sck_in = 1'b1;
                repeat (4) @(negedge clk);
            end else begin
                while (sck_out_m !== 1'b1) @(negedge clk);
                if (sdo_m !== om[7-k]) r4_ok = 1'b0;
            end
        end
        if (ext) begin
            chk(om == tx, "R7 msb-first sdo order", om, tx);
            chk(rx_m == em, "R7 msb-first receive", rx_m, em);
        end else begin
            chk(om == tx, "R2 msb-first sdo order", om, tx);
            chk(rx_m == em, "R2 msb-first receive", rx_m, em);
            chk(r4_ok, "R4 sdo stable while clock high", {7'd0, r4_ok}, 8'd1);
        end
        chk(ol == tx, "R3 lsb-first sdo order", ol, tx);
        chk(rx_l == stream, "R3 lsb-first receive", rx_l, stream);
        chk(done_m && !busy_m, "R5 done after eight rising edges", {6'd0, done_m, busy_m}, 8'h2);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 200 && !done_m; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(done_m == 1'b0, "R1 done after reset", {7'd0, done_m}, 8'd0);
        chk(busy_m == 1'b0, "R1 busy after reset", {7'd0, busy_m}, 8'd0);
        chk(sdo_m == 1'b1, "R1 sdo after reset", {7'd0, sdo_m}, 8'd1);
        chk(sck_out_m == 1'b1, "R1 clock idle after reset", {7'd0, sck_out_m}, 8'd1);
        chk(sdio_oe_m == 1'b0, "R1 shared line off after reset", {7'd0, sdio_oe_m}, 8'd0);

        for (int v = 0; v < 6; v++) begin
            run_xfer(VEC[v][16], VEC[v][15:8], VEC[v][7:0], -1);
            repeat (3) @(negedge clk);
        end
        use_ext_clk = 1'b0;

        // R5 done holds, then clears on a new start
        repeat (10) @(negedge clk);
        chk(done_m == 1'b1, "R5 done holds while idle", {7'd0, done_m}, 8'd1);
        tx_data = 8'h3C;
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk(done_m == 1'b0 && busy_m == 1'b1, "R5 start clears done", {6'd0, done_m, busy_m}, 8'h1);

        // R6 shift clock period is two tap periods
        begin
            int n;
            n = 0;
            while (sck_out_m !== 1'b0) @(negedge clk);
            while (sck_out_m !== 1'b1) begin @(negedge clk); n++; end
            while (sck_out_m !== 1'b0) begin @(negedge clk); n++; end
            chk(n == 4, "R6 shift clock period in cycles", 8'(n), 8'd4);
            chk(sck_oe_m == 1'b1, "R6 clock pin drives", {7'd0, sck_oe_m}, 8'd1);
        end
        wait_done();
        repeat (3) @(negedge clk);

        // R10 restart mid-transfer is ignored
        run_xfer(1'b0, 8'hC6, 8'h2B, 3);
        repeat (3) @(negedge clk);

        // R9 shared data line
        shared_io = 1'b1; shared_dir_out = 1'b1;
        @(negedge clk);
        chk(sdio_oe_m == 1'b1 && sdio_out_m == sdo_m, "R9 shared line drives sdo",
            {6'd0, sdio_oe_m, sdio_out_m}, {6'd0, 1'b1, sdo_m});
        shared_dir_out = 1'b0;
        @(negedge clk);
        chk(sdio_oe_m == 1'b0, "R9 shared line input direction", {7'd0, sdio_oe_m}, 8'd0);
        shared_dir_out = 1'b1; ser_en = 1'b0;
        @(negedge clk);
        chk(sdio_oe_m == 1'b0, "R9 shared line off when disabled", {7'd0, sdio_oe_m}, 8'd0);
        shared_io = 1'b0; shared_dir_out = 1'b0;

        // R8 disabled: clock pin follows the tap, start ignored
        begin
            logic follow;
            follow = 1'b1;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (sck_out_m !== pre_tap || sck_oe_m !== 1'b1) follow = 1'b0;
            end
            chk(follow, "R8 clock pin carries tap", {7'd0, follow}, 8'd1);
        end
        start = 1'b1; @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk(busy_m == 1'b0, "R8 start ignored when disabled", {7'd0, busy_m}, 8'd0);
        ser_en = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule